// File: doc/BRIEF.md
# Clock Source Selection Unit

This block forms the clocks that a small chip's logic runs on. Five free-running source clocks arrive from outside: a fast internal oscillator, a fast external oscillator, a PLL output, a slow external crystal and a slow internal oscillator. A set of 2-bit and 1-bit select inputs chooses which source drives each of five outputs. The outputs are the system clock, the PLL reference, the real-time-clock source, a debug clock pin and the USB clock. The oscillators and the PLL are not modelled here. They appear only as input clocks.

Every output has its own glitch-free selector with its own set of candidate sources. When a select changes, the selector first stops the old clock while it is low. Only after that does it start the new clock, so no output ever carries a pulse shorter than a half-period of the sources involved. Fixed-ratio taps feed some selector inputs: half of the PLL, half of each fast oscillator, the fast external oscillator divided by 128, and the PLL divided by 1.5. Status outputs report which source each selector is actually driving.

Top module: `clk_sel_unit`

## Requirements
- R1: `sys_sel` picks the system clock source: 00 selects the fast internal clock, 01 selects the fast external clock, and 10 or 11 selects the PLL.
- R2: `sys_stat` reports the source driving `sys_clk`, coded 00 internal, 01 external, 10 PLL, 11 none. Right after `sys_sel` changes, it still shows the old source, and it shows the new one once the switch has finished.
- R3: Switching is glitch-free. At most one source of a selector is enabled at any time, and `sys_clk` never has a high or low phase shorter than the shortest source half-period.
- R4: `pllref_sel` picks the PLL reference: 00 gives the fast internal clock divided by 2, 01 the fast external clock, 10 the fast external clock divided by 2, and 11 gives no clock (output held low).
- R5: `rtc_sel` picks the real-time-clock source: 00 gives no clock (output held low), 01 the slow external clock, 10 the slow internal clock, and 11 the fast external clock divided by 128.
- R6: The divide-by-128 tap has a period of exactly 128 fast external periods.
- R7: `mco_sel` picks the debug clock pin: 00 the system clock, 01 the fast internal clock, 10 the fast external clock, and 11 the PLL divided by 2.
- R8: `usb_div15` = 0 gives the PLL clock on `usb_clk`. A value of 1 gives the PLL divided by 1.5, which is high for one PLL half-period and low for two.
- R9: While `rst_n` is low, every clock output is low, `sys_stat` is 11 and every active vector is zero.
- R10: The one-hot active vectors show the enabled input of each selector. `pllref_act` uses bit0 for internal/2, bit1 for external and bit2 for external/2. `rtc_act` uses bit0 for slow external, bit1 for slow internal and bit2 for external/128. `mco_act` has bit k set for `mco_sel` = k. `usb_act` uses bit0 for the PLL and bit1 for PLL/1.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hsi | input | 1 | Fast internal oscillator clock |
| clk_hse | input | 1 | Fast external oscillator clock |
| clk_pll | input | 1 | PLL output clock |
| clk_lse | input | 1 | Slow external crystal clock |
| clk_lsi | input | 1 | Slow internal oscillator clock |
| sys_sel | input | 2 | System clock source select |
| pllref_sel | input | 2 | PLL reference select |
| rtc_sel | input | 2 | Real-time-clock source select |
| mco_sel | input | 2 | Debug clock pin select |
| usb_div15 | input | 1 | USB clock ratio select |
| sys_clk | output | 1 | System clock |
| sys_stat | output | 2 | Active system clock source code |
| pllref_clk | output | 1 | PLL reference clock |
| rtc_clk | output | 1 | Real-time-clock source |
| mco_clk | output | 1 | Debug clock pin output |
| usb_clk | output | 1 | USB clock |
| pllref_act | output | 3 | Enabled PLL reference input, one-hot |
| rtc_act | output | 3 | Enabled real-time-clock input, one-hot |
| mco_act | output | 4 | Enabled debug-pin input, one-hot |
| usb_act | output | 2 | Enabled USB input, one-hot |

## Verification
The handshake assertions take three things for granted. Every source clock keeps toggling, reset is released once, and a select input changes no more often than a switch can complete. Without this, a stopped old clock would leave its enable set forever. The stimulus keeps every source running for the whole test. It changes the selects only after a settling time longer than three periods of the slowest candidate, which is the external clock divided by 128. It also counts output edges only inside a window that begins after that settling time.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    typedef enum logic [1:0] {
        SRC_HSI  = 2'b00,
        SRC_HSE  = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_NONE = 2'b11
    } sys_src_e;

    // two-stage handshake synchroniser of one selector input
    typedef struct packed {
        logic meta;
        logic sync;
    } hs_sync_t;

    // rising-edge half of the divide-by-1.5 tap
    typedef struct packed {
        logic [1:0] phase;
        logic       rise_tgl;
    } d15_rise_t;

endpackage

// File: rtl/clk_div_pow2.sv
`timescale 1ns/1ps
module clk_div_pow2 #(
    parameter int LOG2 = 1
) (
    input  logic rst_n,
    input  logic clk,
    output logic clk_out
);
    localparam int W = (LOG2 < 1) ? 1 : LOG2;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clk_out = cnt_q[W-1];

    // R6: counter wraps after 2**LOG2 input periods
    a_r6_wrap_full_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '0));

endmodule

// File: rtl/clk_div_1p5.sv
`timescale 1ns/1ps
module clk_div_1p5 (
    input  logic rst_n,
    input  logic clk,
    output logic clk_out
);
    import clksel_pkg::*;

    d15_rise_t rise_d, rise_q;
    logic      fall_d, fall_q;

    // phase counts input cycles 0,1,2; each edge flips at most one flop
    always_comb begin
        rise_d.phase    = (rise_q.phase == 2'd2) ? 2'd0 : rise_q.phase + 2'd1;
        rise_d.rise_tgl = (rise_q.phase != 2'd1) ? ~rise_q.rise_tgl : rise_q.rise_tgl;
        fall_d          = (rise_q.phase != 2'd0) ? ~fall_q : fall_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
    end

    assign clk_out = rise_q.rise_tgl ^ fall_q;

    // R8: three-state phase counter never reaches the unused code
    a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q.phase != 2'd3);

endmodule

// File: rtl/gf_clk_mux.sv
`timescale 1ns/1ps
module gf_clk_mux #(
    parameter int N = 3
) (
    input  logic         rst_n,
    input  logic [N-1:0] clk_in,
    input  logic [N-1:0] req,
    output logic         clk_out,
    output logic [N-1:0] active
);
    import clksel_pkg::*;

    logic [N-1:0] en_vec;
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam logic [N-1:0] SELF = {{(N-1){1'b0}}, 1'b1} << i;

        hs_sync_t sy_d, sy_q;
        logic     en_d, en_q;
        logic     others_on;

        always_comb begin
            others_on = |(en_vec & ~SELF);
            sy_d.meta = req[i] & ~others_on;
            sy_d.sync = sy_q.meta;
            en_d      = sy_q.sync;
        end

        always_ff @(posedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) sy_q <= '0;
            else        sy_q <= sy_d;
        end

        // enable moves only while this source is low
        always_ff @(negedge clk_in[i] or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_d;
        end

        assign en_vec[i] = en_q;
        assign gated[i]  = clk_in[i] & en_q;

        // R3: never two sources enabled together
        a_r3_single_source: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
            $onehot0(en_vec));

        // R3: an enable can only appear after passing the handshake
        a_r3_enable_via_sync: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
            (!en_q && !sy_q.sync && !sy_q.meta) |=> !en_q);
    end

    assign clk_out = |gated;
    assign active  = en_vec;

endmodule

// File: rtl/clk_sel_unit.sv
`timescale 1ns/1ps
module clk_sel_unit (
    input  logic       rst_n,
    input  logic       clk_hsi,
    input  logic       clk_hse,
    input  logic       clk_pll,
    input  logic       clk_lse,
    input  logic       clk_lsi,
    input  logic [1:0] sys_sel,
    input  logic [1:0] pllref_sel,
    input  logic [1:0] rtc_sel,
    input  logic [1:0] mco_sel,
    input  logic       usb_div15,
    output logic       sys_clk,
    output logic [1:0] sys_stat,
    output logic       pllref_clk,
    output logic       rtc_clk,
    output logic       mco_clk,
    output logic       usb_clk,
    output logic [2:0] pllref_act,
    output logic [2:0] rtc_act,
    output logic [3:0] mco_act,
    output logic [1:0] usb_act
);
    import clksel_pkg::*;

    localparam int SLOW_DIV_LOG2 = 7;

    logic pll_d2, hse_d2, hsi_d2, hse_d128, pll_d15;
    logic [2:0] sys_req, sys_act, pref_req, rtc_req;
    logic [3:0] mco_req;
    logic [1:0] usb_req;
    sys_src_e   stat_code;

    clk_div_pow2 #(.LOG2(1)) u_pll_d2 (.rst_n(rst_n), .clk(clk_pll), .clk_out(pll_d2));
    clk_div_pow2 #(.LOG2(1)) u_hse_d2 (.rst_n(rst_n), .clk(clk_hse), .clk_out(hse_d2));
    clk_div_pow2 #(.LOG2(1)) u_hsi_d2 (.rst_n(rst_n), .clk(clk_hsi), .clk_out(hsi_d2));
    clk_div_pow2 #(.LOG2(SLOW_DIV_LOG2)) u_hse_d128 (.rst_n(rst_n), .clk(clk_hse), .clk_out(hse_d128));
    clk_div_1p5 u_pll_d15 (.rst_n(rst_n), .clk(clk_pll), .clk_out(pll_d15));

    always_comb begin
        unique case (sys_sel)
            2'b00:   sys_req = 3'b001;
            2'b01:   sys_req = 3'b010;
            default: sys_req = 3'b100;
        endcase
        unique case (pllref_sel)
            2'b00:   pref_req = 3'b001;
            2'b01:   pref_req = 3'b010;
            2'b10:   pref_req = 3'b100;
            default: pref_req = 3'b000;
        endcase
        unique case (rtc_sel)
            2'b01:   rtc_req = 3'b001;
            2'b10:   rtc_req = 3'b010;
            2'b11:   rtc_req = 3'b100;
            default: rtc_req = 3'b000;
        endcase
        mco_req = 4'b0001 << mco_sel;
        usb_req = usb_div15 ? 2'b10 : 2'b01;
    end

    gf_clk_mux #(.N(3)) u_sys_mux (
        .rst_n(rst_n), .clk_in({clk_pll, clk_hse, clk_hsi}), .req(sys_req),
        .clk_out(sys_clk), .active(sys_act));

    gf_clk_mux #(.N(3)) u_pref_mux (
        .rst_n(rst_n), .clk_in({hse_d2, clk_hse, hsi_d2}), .req(pref_req),
        .clk_out(pllref_clk), .active(pllref_act));

    gf_clk_mux #(.N(3)) u_rtc_mux (
        .rst_n(rst_n), .clk_in({hse_d128, clk_lsi, clk_lse}), .req(rtc_req),
        .clk_out(rtc_clk), .active(rtc_act));

    gf_clk_mux #(.N(4)) u_mco_mux (
        .rst_n(rst_n), .clk_in({pll_d2, clk_hse, clk_hsi, sys_clk}), .req(mco_req),
        .clk_out(mco_clk), .active(mco_act));

    gf_clk_mux #(.N(2)) u_usb_mux (
        .rst_n(rst_n), .clk_in({pll_d15, clk_pll}), .req(usb_req),
        .clk_out(usb_clk), .active(usb_act));

    always_comb begin
        unique case (sys_act)
            3'b001:  stat_code = SRC_HSI;
            3'b010:  stat_code = SRC_HSE;
            3'b100:  stat_code = SRC_PLL;
            default: stat_code = SRC_NONE;
        endcase
    end

    assign sys_stat = stat_code;

    // R2: a source code shown in the status is one the system selector enabled
    a_r2_stat_has_source: assert property (@(posedge clk_hsi) disable iff (!rst_n)
        (sys_stat != 2'b11) |-> (sys_act != 3'b000));

endmodule

// File: tb/tb_clk_sel_unit.sv
`timescale 1ns/1ps
module tb_clk_sel_unit;

    localparam real TB_CLK_NS = 10.0;
    localparam real WIN_NS    = 18000.0;
    localparam real SETTLE_NS = 14000.0;
    localparam int  WD_LIMIT  = 150000;
    localparam int  NVEC      = 7;

    // sys, pllref, rtc, mco, usb select; expected periods (0 = no clock); stat
    typedef struct packed {
        logic [1:0]  s_sys, s_pref, s_rtc, s_mco;
        logic        s_usb;
        logic [15:0] p_sys, p_pref, p_rtc, p_mco, p_usb;
        logic [1:0]  stat;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 16'd10, 16'd20, 16'd46,   16'd10, 16'd6, 2'b00},
        '{2'b01, 2'b01, 2'b10, 2'b01, 1'b1, 16'd14, 16'd14, 16'd34,   16'd10, 16'd9, 2'b01},
        '{2'b10, 2'b10, 2'b11, 2'b10, 1'b0, 16'd6,  16'd28, 16'd1792, 16'd14, 16'd6, 2'b10},
        '{2'b11, 2'b11, 2'b00, 2'b11, 1'b1, 16'd6,  16'd0,  16'd0,    16'd12, 16'd9, 2'b10},
        '{2'b00, 2'b01, 2'b11, 2'b00, 1'b0, 16'd10, 16'd14, 16'd1792, 16'd10, 16'd6, 2'b00},
        '{2'b01, 2'b00, 2'b01, 2'b00, 1'b1, 16'd14, 16'd20, 16'd46,   16'd14, 16'd9, 2'b01},
        '{2'b10, 2'b10, 2'b10, 2'b11, 1'b0, 16'd6,  16'd28, 16'd34,   16'd12, 16'd6, 2'b10}
    };

    logic tb_clk = 1'b0, clk_hsi = 1'b0, clk_hse = 1'b0, clk_pll = 1'b0;
    logic clk_lse = 1'b0, clk_lsi = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sys_sel = '0, pllref_sel = '0, rtc_sel = '0, mco_sel = '0;
    logic usb_div15 = 1'b0;
    logic sys_clk, pllref_clk, rtc_clk, mco_clk, usb_clk;
    logic [1:0] sys_stat, usb_act;
    logic [2:0] pllref_act, rtc_act;
    logic [3:0] mco_act;

    always #(TB_CLK_NS / 2.0) tb_clk = ~tb_clk;
    always #5  clk_hsi = ~clk_hsi;
    always #7  clk_hse = ~clk_hse;
    always #3  clk_pll = ~clk_pll;
    always #23 clk_lse = ~clk_lse;
    always #17 clk_lsi = ~clk_lsi;

    clk_sel_unit dut (
        .rst_n(rst_n), .clk_hsi(clk_hsi), .clk_hse(clk_hse), .clk_pll(clk_pll),
        .clk_lse(clk_lse), .clk_lsi(clk_lsi), .sys_sel(sys_sel), .pllref_sel(pllref_sel),
        .rtc_sel(rtc_sel), .mco_sel(mco_sel), .usb_div15(usb_div15), .sys_clk(sys_clk),
        .sys_stat(sys_stat), .pllref_clk(pllref_clk), .rtc_clk(rtc_clk), .mco_clk(mco_clk),
        .usb_clk(usb_clk), .pllref_act(pllref_act), .rtc_act(rtc_act), .mco_act(mco_act),
        .usb_act(usb_act));

    int n_tests = 0, n_fail = 0, wd_cnt = 0;
    int c_sys = 0, c_pref = 0, c_rtc = 0, c_mco = 0, c_usb = 0;
    real t_sys = 0.0, min_sys_w = 1.0e9;
    real t_usb_rise = 0.0, usb_hi = 0.0, usb_per = 0.0;

    always @(posedge sys_clk)    c_sys++;
    always @(posedge pllref_clk) c_pref++;
    always @(posedge rtc_clk)    c_rtc++;
    always @(posedge mco_clk)    c_mco++;
    always @(posedge usb_clk) begin
        c_usb++;
        if (t_usb_rise > 0.0) usb_per = $realtime - t_usb_rise;
        t_usb_rise = $realtime;
    end
    always @(negedge usb_clk) usb_hi = $realtime - t_usb_rise;

    // shortest phase seen on the system clock after reset
    always @(sys_clk) begin
        if (rst_n && t_sys > 0.0 && ($realtime - t_sys) < min_sys_w)
            min_sys_w = $realtime - t_sys;
        t_sys = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic chk_rate(input string req, input string what, input int cnt,
                            input int per);
        real expv;
        expv = (per == 0) ? 0.0 : WIN_NS / real'(per);
        chk((real'(cnt) - expv) <= 2.0 && (expv - real'(cnt)) <= 2.0, req, what,
            real'(cnt), expv);
    endtask

    function automatic logic [2:0] exp_pref(input logic [1:0] s);
        return (s == 2'b11) ? 3'b000 : (3'b001 << s);      // R4 / R10 encoding
    endfunction
    function automatic logic [2:0] exp_rtc(input logic [1:0] s);
        return (s == 2'b00) ? 3'b000 : (3'b001 << (s - 2'b01)); // R5 / R10 encoding
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge tb_clk);
            wd_cnt++;
            if (wd_cnt > WD_LIMIT) begin
                n_fail++; n_tests++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", wd_cnt, WD_LIMIT);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        logic [1:0] prev_stat;
        sys_sel = VECS[0].s_sys; pllref_sel = VECS[0].s_pref; rtc_sel = VECS[0].s_rtc;
        mco_sel = VECS[0].s_mco; usb_div15 = VECS[0].s_usb;
        #40.3;
        // R9: reset state
        chk({sys_clk, pllref_clk, rtc_clk, mco_clk, usb_clk} == 5'b0, "R9", "clocks low in reset",
            real'({sys_clk, pllref_clk, rtc_clk, mco_clk, usb_clk}), 0.0);
        chk(sys_stat == 2'b11, "R9", "stat in reset", real'(sys_stat), 3.0);
        chk({pllref_act, rtc_act, mco_act, usb_act} == '0, "R9", "actives in reset",
            real'({pllref_act, rtc_act, mco_act, usb_act}), 0.0);
        rst_n = 1'b1;
        #(SETTLE_NS);
        prev_stat = sys_stat;

        for (int v = 0; v < NVEC; v++) begin
            sys_sel = VECS[v].s_sys; pllref_sel = VECS[v].s_pref; rtc_sel = VECS[v].s_rtc;
            mco_sel = VECS[v].s_mco; usb_div15 = VECS[v].s_usb;
            #0.2;
            // R2: status still names the old source right after a select change
            chk(sys_stat == prev_stat, "R2", "stat before switch completes",
                real'(sys_stat), real'(prev_stat));
            #(SETTLE_NS);
            c_sys = 0; c_pref = 0; c_rtc = 0; c_mco = 0; c_usb = 0;
            #(WIN_NS);
            chk_rate("R1", "sys_clk edges", c_sys, int'(VECS[v].p_sys));
            chk_rate("R4", "pllref_clk edges", c_pref, int'(VECS[v].p_pref));
            chk_rate("R5 R6", "rtc_clk edges", c_rtc, int'(VECS[v].p_rtc));
            chk_rate("R7", "mco_clk edges", c_mco, int'(VECS[v].p_mco));
            chk_rate("R8", "usb_clk edges", c_usb, int'(VECS[v].p_usb));
            chk(sys_stat == VECS[v].stat, "R2", "stat after switch",
                real'(sys_stat), real'(VECS[v].stat));
            chk(pllref_act == exp_pref(VECS[v].s_pref), "R10", "pllref_act",
                real'(pllref_act), real'(exp_pref(VECS[v].s_pref)));
            chk(rtc_act == exp_rtc(VECS[v].s_rtc), "R10", "rtc_act",
                real'(rtc_act), real'(exp_rtc(VECS[v].s_rtc)));
            chk(mco_act == (4'b0001 << VECS[v].s_mco), "R10", "mco_act",
                real'(mco_act), real'(4'b0001 << VECS[v].s_mco));
            chk(usb_act == (VECS[v].s_usb ? 2'b10 : 2'b01), "R10", "usb_act",
                real'(usb_act), real'(VECS[v].s_usb ? 2'b10 : 2'b01));
            if (VECS[v].s_usb) begin
                // R8: PLL/1.5 high one PLL half-period, period 1.5 PLL periods
                chk(usb_hi > 2.9 && usb_hi < 3.1, "R8", "usb high time", usb_hi, 3.0);
                chk(usb_per > 8.9 && usb_per < 9.1, "R8", "usb period", usb_per, 9.0);
            end
            prev_stat = sys_stat;
        end

        // R3: no short phase on the system clock across all switches
        chk(min_sys_w > 2.9, "R3", "shortest sys_clk phase", min_sys_w, 3.0);

        // R9: reset again stops every output
        rst_n = 1'b0;
        #20.0;
        chk({sys_clk, pllref_clk, rtc_clk, mco_clk, usb_clk} == 5'b0, "R9", "clocks low in 2nd reset",
            real'({sys_clk, pllref_clk, rtc_clk, mco_clk, usb_clk}), 0.0);
        chk(sys_stat == 2'b11, "R9", "stat in 2nd reset", real'(sys_stat), 3.0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule